// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steps a CPU clock domain through a frequency change while its main PLL is being reprogrammed elsewhere. It runs in two phases. In the pre-change phase it finds the divider settings for the requested rate in a parameter table. It then parks the domain on an alternate clock source, divided down when needed so the CPU clock never runs faster than the old or the new operating point allows. After that it loads the divider registers for the new rate. In the post-change phase it moves the domain back to the main PLL and clears the temporary ratio.

All register traffic goes over a simple single-cycle write/read port toward the clock controller. The read data is combinational. After every write the sequencer polls a stabilization status word, and each poll has a bounded timeout. A timeout is recorded in a sticky flag, and the sequence then carries on with the next step. A start pulse with a phase select and three rates (new, old and alternate, in Hz) launches one phase. Completion is reported by a one-cycle done pulse.

Register word addresses on the port: 0 source select, 1 mux status, 2 divider 0, 3 divider 1, 4 divider-0 status, 5 divider-1 status.

Top module: `ccseq_top`

## Requirements
- R1: After reset, busy, done, err_cfg, err_timeout and warn_div are low, and reg_wr and reg_rd stay low until a start is accepted.
- R2: A pre-change start, or a post-change start when the debug-divider option is on, scans the table for an entry whose kHz value times 1000 equals new_rate_hz. A zero-kHz entry or the table end stops the scan. In that case err_cfg is set, done pulses and no register is written.
- R3: The safe divider is applied in the pre-change phase only when alt_rate_hz > old_rate_hz or old_rate_hz > new_rate_hz. Otherwise the first write is the source-select write.
- R4: The safe ratio is ceil(alt_rate_hz / min(old_rate_hz, new_rate_hz)) - 1. When that value is 8 or more, the ratio saturates at 7 and warn_div is set.
- R5: The safe divider is a read-modify-write of address 2. The ratio goes into bits 2:0. With the debug-divider option on, bits 18:16 are forced to all ones. All other bits keep their read value. The sequencer then polls address 4 until the bits under that mask read zero.
- R6: The pre-change phase then writes address 0 with bit 16 set and polls address 1 until bits 18:16 equal 2. Next it writes address 2 with the table value OR-ed with the safe field (or the plain table value when no safe divider applies) and polls address 4 until the whole word is zero. Last it writes address 3 and polls address 5 until zero.
- R7: When bit 20 of the source-select word is set, the divider-1 write keeps the current register value in bits 6:4 and 2:0, and takes the table value in all other bits.
- R8: The post-change phase writes address 0 with bit 16 cleared and polls address 1 until bits 18:16 equal 1. It then read-modify-writes address 2 with bits 2:0 cleared and, with the debug option on, bits 18:16 taken from the table. Finally it polls address 4 under that mask.
- R9: A poll that has not succeeded after TIMEOUT_CYC reads sets err_timeout, and the sequence continues with the following step.
- R10: err_cfg, err_timeout and warn_div hold their value until the next accepted start, which clears them.
- R11: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse, and busy is low in the cycle after it. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one phase (accepted only when idle) |
| phase_post | input | 1 | 0 = pre-change phase, 1 = post-change phase |
| new_rate_hz | input | 32 | Target PLL rate in Hz |
| old_rate_hz | input | 32 | Current PLL rate in Hz |
| alt_rate_hz | input | 32 | Alternate source rate in Hz |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 3 | Register word address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the same cycle as reg_rd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_cfg | output | 1 | Sticky: no table entry for the new rate |
| err_timeout | output | 1 | Sticky: a stabilization poll timed out |
| warn_div | output | 1 | Sticky: safe ratio saturated |

## Verification
The bench builds the block with divider 1 present, the debug-divider option on, a six-entry table that ends in a zero entry, and TIMEOUT_CYC of 16. This keeps a stuck status poll short enough to run to expiry. It also exercises the debug field forcing and restore, the bit-20 merge into divider 1, and a table miss through the terminator. Rate triples are chosen to reach each way of entering the safe path: the alternate source above the old rate, a step down, and saturation of the ratio at 7.

// File: rtl/ccseq_pkg.sv
package ccseq_pkg;

   localparam int unsigned REG_DW = 32;
   localparam int unsigned REG_AW = 3;

   // register word addresses on the controller port
   localparam logic [REG_AW-1:0] ADR_SRC   = 3'd0;
   localparam logic [REG_AW-1:0] ADR_MUXST = 3'd1;
   localparam logic [REG_AW-1:0] ADR_DIV0  = 3'd2;
   localparam logic [REG_AW-1:0] ADR_DIV1  = 3'd3;
   localparam logic [REG_AW-1:0] ADR_DST0  = 3'd4;
   localparam logic [REG_AW-1:0] ADR_DST1  = 3'd5;

   // bit positions the controller decodes
   localparam int unsigned SEL_ALT_BIT = 16;
   localparam int unsigned HPM_SRC_BIT = 20;
   localparam int unsigned MUXST_POS   = 16;
   localparam int unsigned MUXST_W     = 3;
   localparam int unsigned DBG_POS     = 16;
   localparam logic [REG_DW-1:0] DIV1_KEEP = 32'h0000_0077;

   localparam logic [MUXST_W-1:0] MUXST_ON_ALT  = 3'd2;
   localparam logic [MUXST_W-1:0] MUXST_ON_MAIN = 3'd1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOOK,
      ST_RD_SRC,
      ST_RD_DIV1,
      ST_RD_DIV0,
      ST_WR_SAFE,
      ST_PL_SAFE,
      ST_WR_SRC,
      ST_PL_MUX,
      ST_WR_DIV0,
      ST_PL_DIV0,
      ST_WR_DIV1,
      ST_PL_DIV1,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/ccseq_cfg_rom.sv
module ccseq_cfg_rom #(
   parameter int unsigned NUM_CFG = 6,
   parameter logic [31:0] CFG_KHZ  [NUM_CFG] = '{default: 32'd0},
   parameter logic [31:0] CFG_DIV0 [NUM_CFG] = '{default: 32'd0},
   parameter logic [31:0] CFG_DIV1 [NUM_CFG] = '{default: 32'd0}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scan,
   input  logic [31:0] target_hz,
   output logic        hit,
   output logic        miss,
   output logic [31:0] div0,
   output logic [31:0] div1
);

   localparam int unsigned IW = $clog2(NUM_CFG + 1);

   logic [IW-1:0] idx_q;
   logic [31:0]   khz_sel;
   logic          at_end;
   logic [63:0]   khz_scaled;

   always_comb begin
      khz_sel = '0;
      div0    = '0;
      div1    = '0;
      for (int i = 0; i < NUM_CFG; i++) begin
         if (idx_q == IW'(i)) begin
            khz_sel = CFG_KHZ[i];
            div0    = CFG_DIV0[i];
            div1    = CFG_DIV1[i];
         end
      end
   end

   assign at_end     = (idx_q == IW'(NUM_CFG));
   assign khz_scaled = 64'(khz_sel) * 64'd1000;
   assign miss       = scan && (at_end || (khz_sel == '0));
   assign hit        = scan && !at_end && (khz_sel != '0) &&
                       (khz_scaled == 64'(target_hz));

   always_ff @(posedge clk) begin
      if (!rst_n)              idx_q <= '0;
      else if (!scan)          idx_q <= '0;
      else if (!hit && !miss)  idx_q <= idx_q + 1'b1;
   end

   AST_SCAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IW'(NUM_CFG)); // R2

endmodule

// File: rtl/ccseq_safe_ratio.sv
module ccseq_safe_ratio #(
   parameter int unsigned RATIO_W = 3
) (
   input  logic [31:0]        alt_hz,
   input  logic [31:0]        old_hz,
   input  logic [31:0]        new_hz,
   output logic               need,
   output logic [RATIO_W-1:0] ratio,
   output logic               warn
);

   localparam int unsigned MAXD = 1 << RATIO_W;
   localparam int unsigned PW   = 32 + RATIO_W + 1;

   logic [31:0]    floor_hz;
   logic [MAXD:1]  above;
   logic [RATIO_W:0] cnt;

   assign floor_hz = (old_hz < new_hz) ? old_hz : new_hz;
   assign need     = (alt_hz > old_hz) || (old_hz > new_hz);

   // ceil(a/t) > k  <=>  a > k*t ; the ratio is the count of such k
   for (genvar k = 1; k <= MAXD; k++) begin : g_cmp
      assign above[k] = PW'(alt_hz) > (PW'(floor_hz) * PW'(k));
   end

   always_comb begin
      cnt = '0;
      for (int k = 1; k < MAXD; k++) cnt = cnt + (RATIO_W + 1)'(above[k]);
   end

   assign ratio = cnt[RATIO_W-1:0];
   assign warn  = above[MAXD];

endmodule

// File: rtl/ccseq_poll.sv
module ccseq_poll #(
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter int unsigned MUX_POS     = 16,
   parameter int unsigned MUX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             is_mux,
   input  logic [MUX_W-1:0] mux_want,
   input  logic [31:0]      mask,
   input  logic [31:0]      status,
   output logic             ok,
   output logic             expire
);

   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

   logic [CW-1:0] cnt_q;
   logic          cond_ok;

   assign cond_ok = is_mux ? (status[MUX_POS +: MUX_W] == mux_want)
                           : ((status & mask) == '0);
   assign ok      = active && cond_ok;
   assign expire  = active && !cond_ok && (cnt_q == CW'(TIMEOUT_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !active) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q < CW'(TIMEOUT_CYC))); // R9

endmodule

// File: rtl/ccseq_top.sv
module ccseq_top
   import ccseq_pkg::*;
#(
   parameter int unsigned NUM_CFG     = 6,
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter int unsigned RATIO_W     = 3,
   parameter bit          HAS_DIV1    = 1'b1,
   parameter bit          DBG_DIV     = 1'b1,
   parameter logic [31:0] CFG_KHZ  [NUM_CFG] = '{32'd1200000, 32'd1000000, 32'd800000,
                                                 32'd500000, 32'd200000, 32'd0},
   parameter logic [31:0] CFG_DIV0 [NUM_CFG] = '{32'h0033_1200, 32'h0024_1100, 32'h0015_1000,
                                                 32'h0016_0100, 32'h0012_0000, 32'h0},
   parameter logic [31:0] CFG_DIV1 [NUM_CFG] = '{32'h0000_0105, 32'h0000_0104, 32'h0000_0103,
                                                 32'h0000_0102, 32'h0000_0101, 32'h0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              phase_post,
   input  logic [31:0]       new_rate_hz,
   input  logic [31:0]       old_rate_hz,
   input  logic [31:0]       alt_rate_hz,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [REG_AW-1:0] reg_addr,
   output logic [REG_DW-1:0] reg_wdata,
   input  logic [REG_DW-1:0] reg_rdata,
   output logic              busy,
   output logic              done,
   output logic              err_cfg,
   output logic              err_timeout,
   output logic              warn_div
);

   localparam logic [31:0] RATIO_MASK = 32'((1 << RATIO_W) - 1);
   localparam logic [31:0] DBG_FORCE  = DBG_DIV ? (RATIO_MASK << DBG_POS) : 32'h0;
   localparam logic [31:0] SAFE_MASK  = RATIO_MASK | DBG_FORCE;
   localparam logic [31:0] SEL_MASK   = 32'h1 << SEL_ALT_BIT;

   // elaboration-time parameter checks
   if (NUM_CFG < 1) begin : g_bad_cfg
      $error("ccseq_top: NUM_CFG must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("ccseq_top: TIMEOUT_CYC must be at least 2");
   end
   if (RATIO_W < 1 || RATIO_W > 4) begin : g_bad_rw
      $error("ccseq_top: RATIO_W must be in 1..4");
   end

   seq_state_e  state_q;
   logic        post_q;
   logic [31:0] new_q, old_q, alt_q;
   logic [31:0] tbl_div0_q, tbl_div1_q;
   logic [31:0] src_q, div0_q, div1_q;
   logic        err_cfg_q, err_to_q, warn_q;

   logic        rom_hit, rom_miss;
   logic [31:0] rom_div0, rom_div1;
   logic        safe_need, safe_warn;
   logic [RATIO_W-1:0] safe_ratio;
   logic        poll_act, poll_mux, poll_ok, poll_exp, poll_adv;
   logic [MUXST_W-1:0] poll_want;
   logic [31:0] poll_mask;
   logic [31:0] pre_safe, post_safe, safe_word, div1_word;

   ccseq_cfg_rom #(
      .NUM_CFG (NUM_CFG),
      .CFG_KHZ (CFG_KHZ),
      .CFG_DIV0(CFG_DIV0),
      .CFG_DIV1(CFG_DIV1)
   ) u_rom (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan     (state_q == ST_LOOK),
      .target_hz(new_q),
      .hit      (rom_hit),
      .miss     (rom_miss),
      .div0     (rom_div0),
      .div1     (rom_div1)
   );

   ccseq_safe_ratio #(.RATIO_W(RATIO_W)) u_ratio (
      .alt_hz(alt_q),
      .old_hz(old_q),
      .new_hz(new_q),
      .need  (safe_need),
      .ratio (safe_ratio),
      .warn  (safe_warn)
   );

   ccseq_poll #(
      .TIMEOUT_CYC(TIMEOUT_CYC),
      .MUX_POS    (MUXST_POS),
      .MUX_W      (MUXST_W)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (poll_act),
      .is_mux  (poll_mux),
      .mux_want(poll_want),
      .mask    (poll_mask),
      .status  (reg_rdata),
      .ok      (poll_ok),
      .expire  (poll_exp)
   );

   assign poll_act = (state_q == ST_PL_SAFE) || (state_q == ST_PL_MUX) ||
                     (state_q == ST_PL_DIV0) || (state_q == ST_PL_DIV1);
   assign poll_mux  = (state_q == ST_PL_MUX);
   assign poll_want = post_q ? MUXST_ON_MAIN : MUXST_ON_ALT;
   assign poll_mask = (state_q == ST_PL_SAFE) ? SAFE_MASK : 32'hFFFF_FFFF;
   assign poll_adv  = poll_ok || poll_exp;

   // divider field values for the two phases
   assign pre_safe  = 32'(safe_ratio) | DBG_FORCE;
   assign post_safe = tbl_div0_q & DBG_FORCE;
   assign safe_word = (div0_q & ~SAFE_MASK) | ((post_q ? post_safe : pre_safe) & SAFE_MASK);

   // divider-1 word: optional merge of the fields kept when bit 20 is set
   if (HAS_DIV1) begin : g_div1
      assign div1_word = src_q[HPM_SRC_BIT] ? ((tbl_div1_q & ~DIV1_KEEP) | (div1_q & DIV1_KEEP))
                                            : tbl_div1_q;
   end else begin : g_no_div1
      assign div1_word = tbl_div1_q;
   end

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         post_q     <= 1'b0;
         new_q      <= '0;
         old_q      <= '0;
         alt_q      <= '0;
         tbl_div0_q <= '0;
         tbl_div1_q <= '0;
         src_q      <= '0;
         div0_q     <= '0;
         div1_q     <= '0;
         err_cfg_q  <= 1'b0;
         err_to_q   <= 1'b0;
         warn_q     <= 1'b0;
      end else begin
         if (poll_exp) err_to_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (start) begin
               post_q    <= phase_post;
               new_q     <= new_rate_hz;
               old_q     <= old_rate_hz;
               alt_q     <= alt_rate_hz;
               err_cfg_q <= 1'b0;
               err_to_q  <= 1'b0;
               warn_q    <= 1'b0;
               state_q   <= (phase_post && !DBG_DIV) ? ST_RD_SRC : ST_LOOK;
            end
            ST_LOOK: begin
               if (rom_hit) begin
                  tbl_div0_q <= rom_div0;
                  tbl_div1_q <= rom_div1;
                  state_q    <= ST_RD_SRC;
               end else if (rom_miss) begin
                  err_cfg_q <= 1'b1;
                  state_q   <= ST_DONE;
               end
            end
            ST_RD_SRC: begin
               src_q <= reg_rdata;
               if (post_q)         state_q <= ST_WR_SRC;
               else if (HAS_DIV1)  state_q <= ST_RD_DIV1;
               else if (safe_need) state_q <= ST_RD_DIV0;
               else                state_q <= ST_WR_SRC;
            end
            ST_RD_DIV1: begin
               div1_q  <= reg_rdata;
               state_q <= safe_need ? ST_RD_DIV0 : ST_WR_SRC;
            end
            ST_RD_DIV0: begin
               div0_q  <= reg_rdata;
               state_q <= ST_WR_SAFE;
            end
            ST_WR_SAFE: begin
               if (!post_q && safe_warn) warn_q <= 1'b1;
               state_q <= ST_PL_SAFE;
            end
            ST_PL_SAFE: if (poll_adv) state_q <= post_q ? ST_DONE : ST_WR_SRC;
            ST_WR_SRC:  state_q <= ST_PL_MUX;
            ST_PL_MUX:  if (poll_adv) state_q <= post_q ? ST_RD_DIV0 : ST_WR_DIV0;
            ST_WR_DIV0: state_q <= ST_PL_DIV0;
            ST_PL_DIV0: if (poll_adv) state_q <= HAS_DIV1 ? ST_WR_DIV1 : ST_DONE;
            ST_WR_DIV1: state_q <= ST_PL_DIV1;
            ST_PL_DIV1: if (poll_adv) state_q <= ST_DONE;
            ST_DONE:    state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   // register port
   always_comb begin
      reg_wr    = 1'b0;
      reg_rd    = 1'b0;
      reg_addr  = ADR_SRC;
      reg_wdata = '0;
      unique case (state_q)
         ST_RD_SRC:  begin reg_rd = 1'b1; reg_addr = ADR_SRC;  end
         ST_RD_DIV1: begin reg_rd = 1'b1; reg_addr = ADR_DIV1; end
         ST_RD_DIV0: begin reg_rd = 1'b1; reg_addr = ADR_DIV0; end
         ST_PL_SAFE,
         ST_PL_DIV0: begin reg_rd = 1'b1; reg_addr = ADR_DST0;  end
         ST_PL_MUX:  begin reg_rd = 1'b1; reg_addr = ADR_MUXST; end
         ST_PL_DIV1: begin reg_rd = 1'b1; reg_addr = ADR_DST1;  end
         ST_WR_SAFE: begin reg_wr = 1'b1; reg_addr = ADR_DIV0; reg_wdata = safe_word; end
         ST_WR_SRC:  begin
            reg_wr    = 1'b1;
            reg_addr  = ADR_SRC;
            reg_wdata = post_q ? (src_q & ~SEL_MASK) : (src_q | SEL_MASK);
         end
         ST_WR_DIV0: begin
            reg_wr    = 1'b1;
            reg_addr  = ADR_DIV0;
            reg_wdata = tbl_div0_q | (safe_need ? (pre_safe & SAFE_MASK) : 32'h0);
         end
         ST_WR_DIV1: begin reg_wr = 1'b1; reg_addr = ADR_DIV1; reg_wdata = div1_word; end
         default: ;
      endcase
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign err_cfg     = err_cfg_q;
   assign err_timeout = err_to_q;
   assign warn_div    = warn_q;

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R11
   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(reg_wr || reg_rd)); // R1
   AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      err_cfg |-> !reg_wr); // R2
   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_timeout && !(start && !busy)) |=> err_timeout); // R10
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!err_cfg && !err_timeout && !warn_div && busy)); // R10

endmodule

// File: tb/ccseq_top_bench.sv
module ccseq_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int TO_CYC     = 16;

   localparam logic [31:0] B_KHZ  [6] = '{32'd1200000, 32'd1000000, 32'd800000,
                                          32'd500000, 32'd200000, 32'd0};
   localparam logic [31:0] B_DIV0 [6] = '{32'h0033_1200, 32'h0024_1100, 32'h0015_1000,
                                          32'h0016_0100, 32'h0012_0000, 32'h0};
   localparam logic [31:0] B_DIV1 [6] = '{32'h0000_0105, 32'h0000_0104, 32'h0000_0103,
                                          32'h0000_0102, 32'h0000_0101, 32'h0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        phase_post = 1'b0;
   logic [31:0] new_rate_hz = '0, old_rate_hz = '0, alt_rate_hz = '0;
   logic        reg_wr, reg_rd;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        busy, done, err_cfg, err_timeout, warn_div;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ccseq_top #(
      .NUM_CFG    (6),
      .TIMEOUT_CYC(TO_CYC),
      .RATIO_W    (3),
      .HAS_DIV1   (1'b1),
      .DBG_DIV    (1'b1),
      .CFG_KHZ    (B_KHZ),
      .CFG_DIV0   (B_DIV0),
      .CFG_DIV1   (B_DIV1)
   ) u_ccseq_top (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_post(phase_post),
      .new_rate_hz(new_rate_hz), .old_rate_hz(old_rate_hz), .alt_rate_hz(alt_rate_hz),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .busy(busy), .done(done), .err_cfg(err_cfg),
      .err_timeout(err_timeout), .warn_div(warn_div)
   );

   // ---------------- clock-controller model ----------------
   logic [31:0] m_src, m_div0, m_div1;
   int          mux_cnt, d0_cnt, d1_cnt;
   logic        mux_stuck;
   logic        ld_req = 1'b0;
   logic [31:0] ld_src = '0, ld_div0 = '0, ld_div1 = '0;
   logic        ld_stuck = 1'b0;
   logic [2:0]  log_a [16];
   logic [31:0] log_d [16];
   int          log_n;

   always @(posedge clk) begin
      if (ld_req) begin
         m_src <= ld_src; m_div0 <= ld_div0; m_div1 <= ld_div1;
         mux_stuck <= ld_stuck;
         mux_cnt <= 0; d0_cnt <= 0; d1_cnt <= 0; log_n <= 0;
      end else begin
         if (mux_cnt > 0) mux_cnt <= mux_cnt - 1;
         if (d0_cnt > 0)  d0_cnt  <= d0_cnt - 1;
         if (d1_cnt > 0)  d1_cnt  <= d1_cnt - 1;
         if (reg_wr) begin
            if (log_n < 16) begin
               log_a[log_n] <= reg_addr;
               log_d[log_n] <= reg_wdata;
            end
            log_n <= log_n + 1;
            case (reg_addr)
               3'd0: begin m_src  <= reg_wdata; mux_cnt <= LAT; end
               3'd2: begin m_div0 <= reg_wdata; d0_cnt  <= LAT; end
               3'd3: begin m_div1 <= reg_wdata; d1_cnt  <= LAT; end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         3'd0: reg_rdata = m_src;
         3'd1: reg_rdata = (mux_cnt != 0 || mux_stuck) ? 32'h0 :
                           (m_src[16] ? 32'h0002_0000 : 32'h0001_0000);
         3'd2: reg_rdata = m_div0;
         3'd3: reg_rdata = m_div1;
         3'd4: reg_rdata = (d0_cnt != 0) ? 32'hFFFF_FFFF : 32'h0;
         3'd5: reg_rdata = (d1_cnt != 0) ? 32'hFFFF_FFFF : 32'h0;
         default: reg_rdata = 32'h0;
      endcase
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_wr(input string req, input int i,
                         input logic [2:0] a, input logic [31:0] d);
      chk(req, $sformatf("write %0d addr", i), 32'(log_a[i]), 32'(a));
      chk(req, $sformatf("write %0d data", i), log_d[i], d);
   endtask

   task automatic load_model(input logic [31:0] s, input logic [31:0] d0,
                             input logic [31:0] d1, input logic stuck);
      @(negedge clk);
      ld_src = s; ld_div0 = d0; ld_div1 = d1; ld_stuck = stuck; ld_req = 1'b1;
      @(negedge clk);
      ld_req = 1'b0;
   endtask

   task automatic run(input logic post, input logic [31:0] nr, input logic [31:0] orr,
                      input logic [31:0] ar, input bit poke);
      int n;
      @(negedge clk);
      phase_post = post; new_rate_hz = nr; old_rate_hz = orr; alt_rate_hz = ar;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "busy after start", 32'(busy), 32'd1);
      if (poke) begin
         @(negedge clk);
         start = 1'b1; phase_post = ~post; new_rate_hz = 32'd7;
         @(negedge clk);
         start = 1'b0; phase_post = post; new_rate_hz = nr;
      end
      n = 0;
      while (done !== 1'b1 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk("R11", "done reached", 32'(done), 32'd1);
      @(negedge clk);
      chk("R11", "busy after done", 32'(busy), 32'd0);
      chk("R11", "done one cycle", 32'(done), 32'd0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1", "busy", 32'(busy), 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "flags", {29'd0, err_cfg, err_timeout, warn_div}, 32'd0);
      chk("R1", "bus idle", {30'd0, reg_wr, reg_rd}, 32'd0);
      chk("R1", "no writes", 32'(log_n), 32'd0);
   endtask

   task automatic t_no_safe;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd1000000000, 32'd800000000, 32'd500000000, 1'b0);
      chk("R3", "write count", 32'(log_n), 32'd3);
      chk_wr("R3", 0, 3'd0, 32'h0001_0001);
      chk_wr("R6", 1, 3'd2, 32'h0024_1100);
      chk_wr("R6", 2, 3'd3, 32'h0000_0104);
      chk("R6", "mux moved to alt", m_src, 32'h0001_0001);
      chk("R9", "no timeout", 32'(err_timeout), 32'd0);
   endtask

   task automatic t_step_down;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd500000000, 32'd1000000000, 32'd800000000, 1'b1);
      chk("R11", "start while busy ignored count", 32'(log_n), 32'd4);
      chk_wr("R5", 0, 3'd2, 32'h0A07_0CC1);
      chk_wr("R6", 1, 3'd0, 32'h0001_0001);
      chk_wr("R6", 2, 3'd2, 32'h0017_0101);
      chk_wr("R6", 3, 3'd3, 32'h0000_0102);
      chk("R4", "no warn", 32'(warn_div), 32'd0);
   endtask

   task automatic t_alt_fast;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd800000000, 32'd500000000, 32'd1200000000, 1'b0);
      chk("R3", "write count", 32'(log_n), 32'd4);
      chk_wr("R4", 0, 3'd2, 32'h0A07_0CC2);
      chk_wr("R6", 2, 3'd2, 32'h0017_1002);
      chk_wr("R6", 3, 3'd3, 32'h0000_0103);
   endtask

   task automatic t_saturate;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd200000000, 32'd200000000, 32'd2000000000, 1'b0);
      chk_wr("R4", 0, 3'd2, 32'h0A07_0CC7);
      chk_wr("R4", 2, 3'd2, 32'h0017_0007);
      chk("R4", "warn set", 32'(warn_div), 32'd1);
   endtask

   task automatic t_hpm_keep;
      load_model(32'h0010_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd800000000, 32'd800000000, 32'd500000000, 1'b0);
      chk("R10", "warn cleared by start", 32'(warn_div), 32'd0);
      chk("R7", "write count", 32'(log_n), 32'd3);
      chk_wr("R7", 0, 3'd0, 32'h0011_0001);
      chk_wr("R7", 2, 3'd3, 32'h0000_0163);
   endtask

   task automatic t_miss;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd123000000, 32'd800000000, 32'd500000000, 1'b0);
      chk("R2", "err_cfg", 32'(err_cfg), 32'd1);
      chk("R2", "no writes", 32'(log_n), 32'd0);
      chk("R2", "div0 untouched", m_div0, 32'h0A00_0CC0);
   endtask

   task automatic t_post;
      load_model(32'h0001_0001, 32'h0017_0101, 32'h0000_0102, 1'b0);
      run(1'b1, 32'd500000000, 32'd1000000000, 32'd800000000, 1'b0);
      chk("R10", "err_cfg cleared by start", 32'(err_cfg), 32'd0);
      chk("R8", "write count", 32'(log_n), 32'd2);
      chk_wr("R8", 0, 3'd0, 32'h0000_0001);
      chk_wr("R8", 1, 3'd2, 32'h0016_0100);
   endtask

   task automatic t_post_miss;
      load_model(32'h0001_0001, 32'h0017_0101, 32'h0000_0102, 1'b0);
      run(1'b1, 32'd7000000, 32'd1000000000, 32'd800000000, 1'b0);
      chk("R2", "post err_cfg", 32'(err_cfg), 32'd1);
      chk("R2", "post no writes", 32'(log_n), 32'd0);
   endtask

   task automatic t_timeout;
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b1);
      run(1'b0, 32'd1000000000, 32'd800000000, 32'd500000000, 1'b0);
      chk("R9", "err_timeout", 32'(err_timeout), 32'd1);
      chk("R9", "continued count", 32'(log_n), 32'd3);
      chk_wr("R9", 1, 3'd2, 32'h0024_1100);
      chk_wr("R9", 2, 3'd3, 32'h0000_0104);
      repeat (4) @(negedge clk);
      chk("R10", "timeout held", 32'(err_timeout), 32'd1);
      load_model(32'h0000_0001, 32'h0A00_0CC0, 32'h0000_0263, 1'b0);
      run(1'b0, 32'd1000000000, 32'd800000000, 32'd500000000, 1'b0);
      chk("R10", "timeout cleared", 32'(err_timeout), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_no_safe();
      t_step_down();
      t_alt_fast();
      t_saturate();
      t_hpm_keep();
      t_miss();
      t_post();
      t_post_miss();
      t_timeout();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule